// File: doc/BRIEF.md
# Load-Linked Reservation Capture Unit

This block carries out the load half of a load-linked / store-conditional pair, for word (4-byte) or doubleword (8-byte) accesses. A request gives a virtual address, a size select and the core's debug-mode flag. An external translation port supplies the matching physical address in the same cycle. The unit first checks alignment. A misaligned request raises a one-cycle address-error-on-load pulse. It also records the faulting virtual address in a bad-address register, but only when the core is not in debug mode.

An aligned request issues a single memory read at the translated address. When the data returns, the unit produces the result: sign-extended for a word, unchanged for a doubleword. In the same step it records the reservation, which is the physical link address, the virtual address and the loaded value. A later store-conditional stage compares against this reservation.

Top module: `linkedLoadCapture`

## Requirements
- R1: After reset, reqReady is 1; excValid, memRdValid, resValid and linkValid are 0; badVaddr, linkPaddr, linkVaddr and linkValue are 0.
- R2: reqDouble = 1 selects a doubleword. A doubleword request is misaligned when reqVaddr[2:0] is nonzero. A word request (reqDouble = 0) is misaligned when reqVaddr[1:0] is nonzero.
- R3: A misaligned request makes excValid high for exactly one cycle, the cycle after acceptance. No memRdValid is raised, and linkPaddr, linkVaddr, linkValue and linkValid keep their values.
- R4: On a misaligned request with reqDebug = 0, badVaddr takes reqVaddr, visible from the cycle excValid is high. With reqDebug = 1, badVaddr is unchanged.
- R5: For an aligned request, memRdValid rises the cycle after acceptance. memRdAddr equals the xlatPaddr sampled at acceptance, and memRdDouble equals reqDouble. memRdValid and memRdAddr hold until a cycle with memRdReady = 1.
- R6: resValid is high for exactly one cycle, the cycle after the cycle in which memRspValid is sampled high while a read is outstanding.
- R7: For a word request, resData is memRspData[31:0] with bit 31 copied into bits 63:32.
- R8: For a doubleword request, resData equals memRspData unchanged.
- R9: The reservation is updated when resValid rises:
  - linkPaddr becomes the translated address.
  - linkVaddr becomes the request's virtual address.
  - linkValue equals resData.
  - linkValid becomes 1 and stays 1 until reset.
- R10: reqReady is 1 only while the unit is idle. It is 0 from the cycle after acceptance until the cycle after excValid or resValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load-linked request present |
| reqReady | output | 1 | Unit idle and accepting a request |
| reqVaddr | input | VA_W | Virtual address of the request |
| reqDouble | input | 1 | 1 = doubleword, 0 = word |
| reqDebug | input | 1 | Core is in debug mode |
| xlatPaddr | input | PA_W | Translated physical address of reqVaddr |
| memRdValid | output | 1 | Memory read request |
| memRdReady | input | 1 | Memory accepts the read |
| memRdAddr | output | PA_W | Physical read address |
| memRdDouble | output | 1 | Read size, 1 = doubleword |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | XLEN | Read data |
| resValid | output | 1 | Result pulse |
| resData | output | XLEN | Loaded, size-adjusted value |
| excValid | output | 1 | Address-error-on-load pulse |
| badVaddr | output | VA_W | Bad virtual address register |
| linkValid | output | 1 | A reservation has been recorded |
| linkPaddr | output | PA_W | Reserved physical address |
| linkVaddr | output | VA_W | Reserved virtual address |
| linkValue | output | XLEN | Reserved value |

## Verification
The assertions assume a few things about the inputs:
- xlatPaddr is valid in the acceptance cycle.
- The memory returns exactly one response per accepted read, and only after it has accepted that read.
- Request fields may change freely outside acceptance.

The stimulus keeps within these limits. Responses are driven only after the read handshake, after a random delay. Translated addresses are random but presented alongside the request. Random sizes, low address bits, debug flags and handshake delays are mixed with directed cases for every low-bit pattern under both sizes, and with words whose sign bit is set or clear.

// File: rtl/llcPkg.sv
package llcPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXC,
    ST_READ,
    ST_WAIT,
    ST_DONE
  } llcState_e;

  typedef struct packed {
    logic capReq;   // latch translated/virtual address and size
    logic setBad;   // write bad-address register
    logic capRsp;   // record reservation from read data
  } llcStrobe_t;
endpackage

// File: rtl/llcData.sv
module llcData
  import llcPkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 40,
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  llcStrobe_t        strb,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqDouble,
  input  logic [PA_W-1:0]   xlatPaddr,
  input  logic [XLEN-1:0]   memRspData,
  output logic              misalign,
  output logic [PA_W-1:0]   pendPaddr,
  output logic              pendDouble,
  output logic [VA_W-1:0]   badVaddr,
  output logic              linkValid,
  output logic [PA_W-1:0]   linkPaddr,
  output logic [VA_W-1:0]   linkVaddr,
  output logic [XLEN-1:0]   linkValue
);
  localparam int WORD_LSB  = $clog2(WORD_W / 8);
  localparam int DWORD_LSB = $clog2(XLEN / 8);

  logic [VA_W-1:0] pendVaddr;
  logic [XLEN-1:0] loadValue;

  // Alignment check against the selected access size
  always_comb begin
    if (reqDouble) misalign = |reqVaddr[DWORD_LSB-1:0];
    else           misalign = |reqVaddr[WORD_LSB-1:0];
  end

  // Size adjustment of the returned data
  generate
    if (XLEN > WORD_W) begin : gExt
      localparam int EXT_W = XLEN - WORD_W;
      always_comb begin
        if (pendDouble) loadValue = memRspData;
        else loadValue = {{EXT_W{memRspData[WORD_W-1]}}, memRspData[WORD_W-1:0]};
      end

      // R7
      word_sign_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strb.capRsp && !pendDouble) |=>
          (linkValue[XLEN-1:WORD_W] == {EXT_W{linkValue[WORD_W-1]}}));
    end else begin : gNoExt
      always_comb loadValue = memRspData;
    end
  endgenerate

  // Pending request registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPaddr  <= '0;
      pendVaddr  <= '0;
      pendDouble <= 1'b0;
    end else if (strb.capReq) begin
      pendPaddr  <= xlatPaddr;
      pendVaddr  <= reqVaddr;
      pendDouble <= reqDouble;
    end
  end

  // Bad-address register
  always_ff @(posedge clk) begin
    if (!rstN)            badVaddr <= '0;
    else if (strb.setBad) badVaddr <= reqVaddr;
  end

  // Reservation triple
  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkValid <= 1'b0;
      linkPaddr <= '0;
      linkVaddr <= '0;
      linkValue <= '0;
    end else if (strb.capRsp) begin
      linkValid <= 1'b1;
      linkPaddr <= pendPaddr;
      linkVaddr <= pendVaddr;
      linkValue <= loadValue;
    end
  end

  // R9
  link_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |=> linkValid);

  // R3
  link_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setBad || (strb.capReq == 1'b0 && strb.capRsp == 1'b0 && misalign && strb.setBad))
      |=> ($stable(linkPaddr) && $stable(linkVaddr) && $stable(linkValue)));
endmodule

// File: rtl/llcCtrl.sv
module llcCtrl
  import llcPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqDebug,
  input  logic       misalign,
  input  logic       memRdReady,
  input  logic       memRspValid,
  output logic       reqReady,
  output logic       memRdValid,
  output logic       excValid,
  output logic       resValid,
  output llcStrobe_t strb
);
  llcState_e state, stateNext;
  logic accept;

  assign reqReady   = (state == ST_IDLE);
  assign accept     = reqValid && reqReady;
  assign excValid   = (state == ST_EXC);
  assign memRdValid = (state == ST_READ);
  assign resValid   = (state == ST_DONE);

  always_comb begin
    strb        = '0;
    strb.capReq = accept && !misalign;
    strb.setBad = accept && misalign && !reqDebug;
    strb.capRsp = (state == ST_WAIT) && memRspValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) stateNext = misalign ? ST_EXC : ST_READ;
      ST_EXC:  stateNext = ST_IDLE;
      ST_READ: if (memRdReady) stateNext = ST_WAIT;
      ST_WAIT: if (memRspValid) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R3
  exc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> (!excValid && reqReady));

  // R3
  exc_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && misalign) |=> (excValid && !memRdValid));

  // R5
  read_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !misalign) |=> (memRdValid && !excValid));

  // R5
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRdReady) |=> memRdValid);

  // R6
  res_after_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capRsp |=> resValid);

  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> (!resValid && reqReady));

  // R10
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqReady, excValid, memRdValid, resValid}));
endmodule

// File: rtl/linkedLoadCapture.sv
module linkedLoadCapture
  import llcPkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 40,
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic            reqDouble,
  input  logic            reqDebug,
  input  logic [PA_W-1:0] xlatPaddr,
  output logic            memRdValid,
  input  logic            memRdReady,
  output logic [PA_W-1:0] memRdAddr,
  output logic            memRdDouble,
  input  logic            memRspValid,
  input  logic [XLEN-1:0] memRspData,
  output logic            resValid,
  output logic [XLEN-1:0] resData,
  output logic            excValid,
  output logic [VA_W-1:0] badVaddr,
  output logic            linkValid,
  output logic [PA_W-1:0] linkPaddr,
  output logic [VA_W-1:0] linkVaddr,
  output logic [XLEN-1:0] linkValue
);
  llcStrobe_t strb;
  logic       misalign;

  llcCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqDebug   (reqDebug),
    .misalign   (misalign),
    .memRdReady (memRdReady),
    .memRspValid(memRspValid),
    .reqReady   (reqReady),
    .memRdValid (memRdValid),
    .excValid   (excValid),
    .resValid   (resValid),
    .strb       (strb)
  );

  llcData #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .XLEN  (XLEN),
    .WORD_W(WORD_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqVaddr  (reqVaddr),
    .reqDouble (reqDouble),
    .xlatPaddr (xlatPaddr),
    .memRspData(memRspData),
    .misalign  (misalign),
    .pendPaddr (memRdAddr),
    .pendDouble(memRdDouble),
    .badVaddr  (badVaddr),
    .linkValid (linkValid),
    .linkPaddr (linkPaddr),
    .linkVaddr (linkVaddr),
    .linkValue (linkValue)
  );

  assign resData = linkValue;

  // R4
  debug_bad_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && misalign && reqDebug) |=> $stable(badVaddr));

  // R4
  bad_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && misalign && !reqDebug) |=> (badVaddr == $past(reqVaddr)));

  // R5
  read_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRdReady) |=> ($stable(memRdAddr) && $stable(memRdDouble)));

  // R9
  res_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> linkValid);

  // R2
  dword_misalign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqDouble && (reqVaddr[2:0] != 3'b000)) |=> excValid);
endmodule

// File: tb/sim_linkedLoadCapture.sv
module sim_linkedLoadCapture;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 64;
  localparam int PA_W = 40;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rstN;
  logic            reqValid, reqReady, reqDouble, reqDebug;
  logic [VA_W-1:0] reqVaddr;
  logic [PA_W-1:0] xlatPaddr;
  logic            memRdValid, memRdReady, memRdDouble;
  logic [PA_W-1:0] memRdAddr;
  logic            memRspValid;
  logic [XLEN-1:0] memRspData;
  logic            resValid, excValid, linkValid;
  logic [XLEN-1:0] resData, linkValue;
  logic [VA_W-1:0] badVaddr, linkVaddr;
  logic [PA_W-1:0] linkPaddr;

  int checks = 0;
  int errors = 0;

  logic [VA_W-1:0] expBad;
  logic [PA_W-1:0] expLinkP;
  logic [VA_W-1:0] expLinkV;
  logic [XLEN-1:0] expLinkVal;
  logic            expLinkValid;

  always #(CLK_PERIOD / 2) clk = ~clk;

  linkedLoadCapture u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqDouble(reqDouble), .reqDebug(reqDebug),
    .xlatPaddr(xlatPaddr), .memRdValid(memRdValid), .memRdReady(memRdReady),
    .memRdAddr(memRdAddr), .memRdDouble(memRdDouble), .memRspValid(memRspValid),
    .memRspData(memRspData), .resValid(resValid), .resData(resData),
    .excValid(excValid), .badVaddr(badVaddr), .linkValid(linkValid),
    .linkPaddr(linkPaddr), .linkVaddr(linkVaddr), .linkValue(linkValue)
  );

  task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit isMisaligned(input logic [VA_W-1:0] va, input bit dbl);
    return dbl ? (va[2:0] != 3'b000) : (va[1:0] != 2'b00);
  endfunction

  function automatic logic [XLEN-1:0] expResult(input logic [XLEN-1:0] d, input bit dbl);
    return dbl ? d : {{32{d[31]}}, d[31:0]};
  endfunction

  task automatic chkLink(input string req);
    chk(linkValid == expLinkValid, req, XLEN'(linkValid), XLEN'(expLinkValid));
    chk(linkPaddr == expLinkP, req, XLEN'(linkPaddr), XLEN'(expLinkP));
    chk(linkVaddr == expLinkV, req, linkVaddr, expLinkV);
    chk(linkValue == expLinkVal, req, linkValue, expLinkVal);
  endtask

  task automatic runOne(input logic [VA_W-1:0] va, input bit dbl, input bit dbg,
                        input logic [PA_W-1:0] pa, input logic [XLEN-1:0] data,
                        input int rdyDelay, input int rspDelay);
    logic [XLEN-1:0] expRes;
    @(negedge clk);
    chk(reqReady == 1'b1, "R10 idle ready", XLEN'(reqReady), 1);
    reqValid = 1'b1; reqVaddr = va; reqDouble = dbl; reqDebug = dbg; xlatPaddr = pa;
    @(negedge clk);
    reqValid = 1'b0; reqVaddr = '0; xlatPaddr = '0;
    chk(reqReady == 1'b0, "R10 busy after accept", XLEN'(reqReady), 0);
    if (isMisaligned(va, dbl)) begin
      if (!dbg) expBad = va;
      chk(excValid == 1'b1, "R2/R3 exception raised", XLEN'(excValid), 1);
      chk(memRdValid == 1'b0, "R3 no read", XLEN'(memRdValid), 0);
      chk(badVaddr == expBad, "R4 bad address", badVaddr, expBad);
      chkLink("R3 reservation kept");
      @(negedge clk);
      chk(excValid == 1'b0, "R3 single pulse", XLEN'(excValid), 0);
      chk(reqReady == 1'b1, "R10 ready after exc", XLEN'(reqReady), 1);
    end else begin
      chk(excValid == 1'b0, "R2 no exception", XLEN'(excValid), 0);
      chk(memRdValid == 1'b1, "R5 read issued", XLEN'(memRdValid), 1);
      chk(memRdAddr == pa, "R5 read address", XLEN'(memRdAddr), XLEN'(pa));
      chk(memRdDouble == dbl, "R5 read size", XLEN'(memRdDouble), XLEN'(dbl));
      for (int i = 0; i < rdyDelay; i++) begin
        @(negedge clk);
        chk(memRdValid == 1'b1 && memRdAddr == pa, "R5 read held",
            XLEN'(memRdAddr), XLEN'(pa));
      end
      memRdReady = 1'b1;
      @(negedge clk);
      memRdReady = 1'b0;
      chk(memRdValid == 1'b0, "R5 read dropped", XLEN'(memRdValid), 0);
      for (int i = 0; i < rspDelay; i++) begin
        @(negedge clk);
        chk(resValid == 1'b0, "R6 no early result", XLEN'(resValid), 0);
      end
      memRspValid = 1'b1; memRspData = data;
      @(negedge clk);
      memRspValid = 1'b0; memRspData = '0;
      expRes = expResult(data, dbl);
      expLinkValid = 1'b1; expLinkP = pa; expLinkV = va; expLinkVal = expRes;
      chk(resValid == 1'b1, "R6 result valid", XLEN'(resValid), 1);
      chk(resData == expRes, dbl ? "R8 doubleword data" : "R7 word sign-extend",
          resData, expRes);
      chkLink("R9 reservation recorded");
      @(negedge clk);
      chk(resValid == 1'b0, "R6 single pulse", XLEN'(resValid), 0);
      chk(reqReady == 1'b1, "R10 ready after result", XLEN'(reqReady), 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; reqVaddr = '0; reqDouble = 1'b0; reqDebug = 1'b0;
    xlatPaddr = '0; memRdReady = 1'b0; memRspValid = 1'b0; memRspData = '0;
    expBad = '0; expLinkP = '0; expLinkV = '0; expLinkVal = '0; expLinkValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1 reqReady", XLEN'(reqReady), 1);
    chk(excValid == 1'b0 && memRdValid == 1'b0 && resValid == 1'b0, "R1 pulses low",
        XLEN'({excValid, memRdValid, resValid}), 0);
    chk(badVaddr == '0, "R1 badVaddr", badVaddr, 0);
    chkLink("R1 reservation clear");

    // Directed: every low-bit pattern for both sizes, debug clear
    for (int lb = 0; lb < 8; lb++) begin
      runOne({32'h1234_5678, 29'h0ABC_DEF0, 3'(lb)}, 1'b0, 1'b0, 40'hAB_CDEF_0120 + 40'(lb),
             64'hFEDC_BA98_8765_4321, 0, 0);
      runOne({32'h8765_4321, 29'h0123_4560, 3'(lb)}, 1'b1, 1'b0, 40'h12_3456_7800 + 40'(lb),
             64'h0123_4567_89AB_CDEF, 1, 1);
    end
    // Debug-mode misaligned: bad address untouched (R4)
    runOne(64'hDEAD_BEEF_0000_0003, 1'b0, 1'b1, 40'h1, 64'h0, 0, 0);
    runOne(64'hDEAD_BEEF_0000_0004, 1'b1, 1'b1, 40'h2, 64'h0, 0, 0);
    // Word with sign bit clear (R7)
    runOne(64'h0000_0000_0000_1000, 1'b0, 1'b1, 40'h55_0000_1000, 64'hFFFF_FFFF_7FFF_FFFF, 2, 3);
    // Aligned in debug mode still loads
    runOne(64'h0000_0000_0000_2008, 1'b1, 1'b1, 40'h55_0000_2008, 64'h8000_0000_0000_0001, 0, 2);

    // Constrained random
    for (int n = 0; n < 400; n++) begin
      logic [VA_W-1:0] va;
      logic [PA_W-1:0] pa;
      bit dbl;
      va = {$urandom, $urandom};
      pa = {8'($urandom), $urandom};
      dbl = 1'($urandom);
      if ($urandom % 2 == 0) va[2:0] = dbl ? 3'b000 : {1'($urandom), 2'b00};
      runOne(va, dbl, 1'($urandom % 4 == 0), pa, {$urandom, $urandom},
             int'($urandom % 4), int'($urandom % 4));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule